// File: doc/BRIEF.md
# Aliased Scalar/Vector Register File

This block stores 32 architectural registers, each 256 bits wide, and presents them through three overlaid views of different widths. The narrow view is 64 bits and serves scalar floating-point operands. The middle view is 128 bits and serves short vectors. The wide view is 256 bits and serves long vectors. Every view indexes the same physical entry. A value written through a narrow view therefore appears as the low slice of the wider views, and it leaves the bits above its width untouched.

The block has two combinational read ports and one synchronous write port. Each port takes a 5-bit register index and a 2-bit view selector, and the write port also has an enable. A read that names the register being written in the same cycle returns the merged result of that write (write-first). Narrow reads are zero-extended to the full 256-bit data bus. Reset is asynchronous and active-low, and it clears every entry.

Top module: `regview_file`

## Requirements
- R1: While reset is held, and after it is released, every register reads as zero through every view.
- R2: A write changes only the entry it names. All other entries keep their contents.
- R3: The view selector encodes 0 = 64-bit, 1 = 128-bit and 2 = 256-bit. A 256-bit write stores all 256 data bits.
- R4: A 64-bit write replaces bits [63:0] of the entry and keeps bits [255:64]. A 128-bit write replaces bits [127:0] and keeps bits [255:128].
- R5: A 128-bit read of register n returns bits [127:0] of the 256-bit entry. A 64-bit read returns bits [63:0].
- R6: A narrow read drives zero on every data bit above its view width.
- R7: A write with view selector 3 does not change any entry.
- R8: A read with view selector 3 returns all zeros.
- R9: A read of the index being written in the same cycle returns the newly written bits merged with the preserved upper bits of the entry.
- R10: The two read ports are independent. Each returns its own index and view in the same cycle.
- R11: No entry changes while the write enable is low, whatever the other write inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; clears all entries |
| rd0_idx | input | 5 | Read port 0 register index |
| rd0_view | input | 2 | Read port 0 view selector |
| rd0_data | output | 256 | Read port 0 data, zero-extended |
| rd1_idx | input | 5 | Read port 1 register index |
| rd1_view | input | 2 | Read port 1 view selector |
| rd1_data | output | 256 | Read port 1 data, zero-extended |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write register index |
| wr_view | input | 2 | Write view selector |
| wr_data | input | 256 | Write data; only the low view-width bits are used |

## Verification
The assertions check the following on every cycle:
- Narrow and illegal-view reads carry zero upper bits.
- A same-index read during a write returns the write data in the written slice.
- The data on a read port stays stable while its index and view are held and no legal, enabled write has hit that entry.

Only the bench's scenarios can show that preserved upper bits keep the values of earlier wide writes. The same holds for aliasing across sequences of mixed-width writes over all 32 entries, and for reset clearing the whole array.

// File: rtl/regview_pkg.sv
package regview_pkg;
    typedef enum logic [1:0] {
        VIEW_FP  = 2'd0,
        VIEW_SV  = 2'd1,
        VIEW_LV  = 2'd2,
        VIEW_BAD = 2'd3
    } view_e;
endpackage

// File: rtl/rvf_merge.sv
module rvf_merge
    import regview_pkg::*;
#(
    parameter int WIDE_W = 256,
    parameter int MID_W  = 128,
    parameter int FP_W   = 64
) (
    input  logic [WIDE_W-1:0] old_entry,
    input  logic [WIDE_W-1:0] new_data,
    input  view_e             view,
    output logic [WIDE_W-1:0] merged,
    output logic              legal
);
    logic [WIDE_W-1:0] keep_lo;

    // Bits owned by the view; the rest come from the old entry.
    always_comb begin
        unique case (view)
            VIEW_FP: keep_lo = {{(WIDE_W-FP_W){1'b0}},  {FP_W{1'b1}}};
            VIEW_SV: keep_lo = {{(WIDE_W-MID_W){1'b0}}, {MID_W{1'b1}}};
            VIEW_LV: keep_lo = {WIDE_W{1'b1}};
            default: keep_lo = '0;
        endcase
    end

    assign merged = (old_entry & ~keep_lo) | (new_data & keep_lo);
    assign legal  = (view != VIEW_BAD);
endmodule

// File: rtl/rvf_slice.sv
module rvf_slice
    import regview_pkg::*;
#(
    parameter int WIDE_W = 256,
    parameter int MID_W  = 128,
    parameter int FP_W   = 64
) (
    input  logic [WIDE_W-1:0] entry,
    input  view_e             view,
    output logic [WIDE_W-1:0] data
);
    always_comb begin
        unique case (view)
            VIEW_FP: data = {{(WIDE_W-FP_W){1'b0}},  entry[FP_W-1:0]};
            VIEW_SV: data = {{(WIDE_W-MID_W){1'b0}}, entry[MID_W-1:0]};
            VIEW_LV: data = entry;
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/rvf_store.sv
module rvf_store #(
    parameter int NUM_REGS = 32,
    parameter int WIDE_W   = 256,
    parameter int NUM_RD   = 2,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           we,
    input  logic [IDX_W-1:0]               widx,
    input  logic [WIDE_W-1:0]              wentry,
    output logic [WIDE_W-1:0]              wold,
    input  logic [NUM_RD-1:0][IDX_W-1:0]   ridx,
    output logic [NUM_RD-1:0][WIDE_W-1:0]  rentry
);
    logic [WIDE_W-1:0] mem_q [NUM_REGS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wentry;
        end
    end

    assign wold = mem_q[widx];

    for (genvar k = 0; k < NUM_RD; k++) begin : g_rd
        assign rentry[k] = mem_q[ridx[k]];
    end
endmodule

// File: rtl/regview_file.sv
module regview_file
    import regview_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int WIDE_W   = 256,
    parameter int MID_W    = 128,
    parameter int FP_W     = 64,
    localparam int IDX_W   = $clog2(NUM_REGS),
    localparam int NUM_RD  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd0_idx,
    input  logic [1:0]        rd0_view,
    output logic [WIDE_W-1:0] rd0_data,
    input  logic [IDX_W-1:0]  rd1_idx,
    input  logic [1:0]        rd1_view,
    output logic [WIDE_W-1:0] rd1_data,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [1:0]        wr_view,
    input  logic [WIDE_W-1:0] wr_data
);
    logic [WIDE_W-1:0]              old_entry;
    logic [WIDE_W-1:0]              merged;
    logic                           view_ok;
    logic                           wr_fire;
    logic [NUM_RD-1:0][IDX_W-1:0]   rd_idx;
    logic [NUM_RD-1:0][1:0]         rd_view;
    logic [NUM_RD-1:0][WIDE_W-1:0]  rd_entry;
    logic [NUM_RD-1:0][WIDE_W-1:0]  rd_out;

    assign rd_idx[0]  = rd0_idx;
    assign rd_idx[1]  = rd1_idx;
    assign rd_view[0] = rd0_view;
    assign rd_view[1] = rd1_view;

    rvf_merge #(.WIDE_W(WIDE_W), .MID_W(MID_W), .FP_W(FP_W)) u_merge (
        .old_entry (old_entry),
        .new_data  (wr_data),
        .view      (view_e'(wr_view)),
        .merged    (merged),
        .legal     (view_ok)
    );

    assign wr_fire = wr_en && view_ok;

    rvf_store #(.NUM_REGS(NUM_REGS), .WIDE_W(WIDE_W), .NUM_RD(NUM_RD)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (wr_fire),
        .widx   (wr_idx),
        .wentry (merged),
        .wold   (old_entry),
        .ridx   (rd_idx),
        .rentry (rd_entry)
    );

    for (genvar k = 0; k < NUM_RD; k++) begin : g_port
        logic [WIDE_W-1:0] src;
        // Write-first bypass for a same-index read.
        assign src = (wr_fire && (rd_idx[k] == wr_idx)) ? merged : rd_entry[k];
        rvf_slice #(.WIDE_W(WIDE_W), .MID_W(MID_W), .FP_W(FP_W)) u_slice (
            .entry (src),
            .view  (view_e'(rd_view[k])),
            .data  (rd_out[k])
        );
    end

    assign rd0_data = rd_out[0];
    assign rd1_data = rd_out[1];
endmodule

// File: rtl/regview_file_chk.sv
module regview_file_chk #(
    parameter int WIDE_W = 256,
    parameter int MID_W  = 128,
    parameter int FP_W   = 64,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [IDX_W-1:0]  rd0_idx,
    input logic [1:0]        rd0_view,
    input logic [WIDE_W-1:0] rd0_data,
    input logic [IDX_W-1:0]  rd1_idx,
    input logic [1:0]        rd1_view,
    input logic [WIDE_W-1:0] rd1_data,
    input logic              wr_en,
    input logic [IDX_W-1:0]  wr_idx,
    input logic [1:0]        wr_view,
    input logic [WIDE_W-1:0] wr_data
);
    assert_rd0_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_view == 2'd0) |-> (rd0_data[WIDE_W-1:FP_W] == '0));

    assert_rd1_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_view == 2'd1) |-> (rd1_data[WIDE_W-1:MID_W] == '0));

    assert_bad_view_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_view == 2'd3) |-> (rd0_data == '0));

    assert_bypass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd2 && rd0_view == 2'd2 && rd0_idx == wr_idx)
        |-> (rd0_data == wr_data));

    assert_fp_alias_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_view == 2'd0 && rd1_view == 2'd2 && rd1_idx == wr_idx)
        |-> (rd1_data[FP_W-1:0] == wr_data[FP_W-1:0]));

    // Covers R7 and R11: no legal enabled write to the entry means no change.
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!(wr_en && wr_view != 2'd3 && wr_idx == rd0_idx))
         && $stable(rd0_idx) && $stable(rd0_view)
         && !(wr_en && wr_view != 2'd3 && wr_idx == rd0_idx))
        |-> $stable(rd0_data));
endmodule

bind regview_file regview_file_chk #(
    .WIDE_W(WIDE_W), .MID_W(MID_W), .FP_W(FP_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_regview_file.sv
module sim_regview_file;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [4:0]   rd0_idx = '0, rd1_idx = '0, wr_idx = '0;
    logic [1:0]   rd0_view = '0, rd1_view = '0, wr_view = '0;
    logic [255:0] rd0_data, rd1_data;
    logic         wr_en = 1'b0;
    logic [255:0] wr_data = '0;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [255:0] model [32];

    always #5 clk = ~clk;

    regview_file u0 (.*);

    function automatic logic [255:0] pat(int i, int k);
        logic [255:0] p;
        for (int w = 0; w < 8; w++)
            p[w*32 +: 32] = 32'((i + 1) * 32'h01000193 + k * 32'h9E3779B9 + w * 32'h00010001);
        return p;
    endfunction

    function automatic logic [255:0] slice(logic [255:0] e, logic [1:0] v);
        case (v)
            2'd0: return {192'd0, e[63:0]};
            2'd1: return {128'd0, e[127:0]};
            2'd2: return e;
            default: return '0;
        endcase
    endfunction

    function automatic logic [255:0] merge(logic [255:0] e, logic [255:0] d, logic [1:0] v);
        case (v)
            2'd0: return {e[255:64], d[63:0]};
            2'd1: return {e[255:128], d[127:0]};
            2'd2: return d;
            default: return e;
        endcase
    endfunction

    task automatic compare(logic [255:0] got, logic [255:0] exp, string req);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(int idx, logic [1:0] v, logic [255:0] d, logic en);
        @(negedge clk);
        wr_en = en; wr_idx = 5'(idx); wr_view = v; wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
        if (en) model[idx] = merge(model[idx], d, v);
    endtask

    task automatic chk(int port, int idx, logic [1:0] v, string req);
        @(negedge clk);
        if (port == 0) begin rd0_idx = 5'(idx); rd0_view = v; end
        else           begin rd1_idx = 5'(idx); rd1_view = v; end
        #1;
        compare(port == 0 ? rd0_data : rd1_data, slice(model[idx], v), req);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) model[i] = '0;
        // R1 during reset
        #2;
        compare(rd0_data, '0, "R1");
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 32; i++) begin
            chk(0, i, 2'd2, "R1");
            chk(1, i, 2'd0, "R1");
        end
        // R3 wide writes, R5/R6 narrow views, R10 second port
        for (int i = 0; i < 32; i++) wr(i, 2'd2, pat(i, 1), 1'b1);
        for (int i = 0; i < 32; i++) begin
            chk(0, i, 2'd2, "R3");
            chk(0, i, 2'd1, "R5");
            chk(0, i, 2'd0, "R6");
            chk(1, 31 - i, 2'd2, "R10");
        end
        // R4 64-bit writes on even entries; odd untouched (R2)
        for (int i = 0; i < 32; i += 2) wr(i, 2'd0, pat(i, 2), 1'b1);
        for (int i = 0; i < 32; i++) chk(0, i, 2'd2, (i % 2 == 0) ? "R4" : "R2");
        // R4 128-bit writes on every third entry
        for (int i = 0; i < 32; i += 3) wr(i, 2'd1, pat(i, 3), 1'b1);
        for (int i = 0; i < 32; i++) begin
            chk(1, i, 2'd2, "R4");
            chk(0, i, 2'd1, "R5");
        end
        // R7 illegal-view writes
        for (int i = 0; i < 32; i++) wr(i, 2'd3, pat(i, 4), 1'b1);
        for (int i = 0; i < 32; i++) chk(0, i, 2'd2, "R7");
        // R11 writes with enable low
        for (int i = 0; i < 32; i++) wr(i, 2'd2, pat(i, 5), 1'b0);
        for (int i = 0; i < 32; i++) chk(1, i, 2'd2, "R11");
        // R8 illegal-view reads
        for (int i = 0; i < 32; i++) chk(0, i, 2'd3, "R8");
        // R9 write-first bypass on both ports, each view
        for (int i = 0; i < 12; i++) begin
            logic [1:0]   v;
            logic [255:0] d;
            logic [255:0] nxt;
            v = 2'(i % 3);
            d = pat(i + 7, 6);
            @(negedge clk);
            wr_en = 1'b1; wr_idx = 5'(i); wr_view = v; wr_data = d;
            rd0_idx = 5'(i); rd0_view = 2'd2;
            rd1_idx = 5'(i); rd1_view = v;
            #1;
            nxt = merge(model[i], d, v);
            compare(rd0_data, nxt, "R9");
            compare(rd1_data, slice(nxt, v), "R9");
            @(posedge clk);
            #1;
            wr_en = 1'b0;
            model[i] = nxt;
            chk(0, i, 2'd2, "R9");
        end
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule